// File: doc/BRIEF.md
# Normalized Lloyd-Max Sample Quantizer

This block turns one signed in-phase or quadrature radar echo sample per clock into a short sign-magnitude code. Before the search, the sample's magnitude is multiplied by a per-block gain word, supplied by an upstream variance estimator, so that every block reaches the same normalized scale. Because of this, one fixed set of non-uniform decision boundaries per output width serves every signal level. The boundaries approximate the Lloyd-Max optimum for a Gaussian source: cells are narrow near zero and widen toward the tails. They are computed at elaboration time, so no memory needs to be loaded.

A width selector picks 2, 3, 4, 6 or 8 output bits for each sample. The interval is found in two phases. First, one rank of parallel comparators places the magnitude in a coarse group. Then a chain of pipelined single-comparator stages halves the group at each step. The latency is the same for every width, so the selector may change on any cycle. A valid flag travels with each sample.

Top module: `lm_quantizer`

## Requirements
- R1: The width select uses 0→2 bits, 1→3, 2→4, 3→6 and 4→8; the values 5, 6 and 7 behave as 8 bits. The code sits in the low N bits of `out_code`, and every bit above the selected width is zero.
- R2: Bit N-1 of the code is 1 exactly when the input sample is negative, where N is the selected width. A zero sample gives a sign bit of 0.
- R3: The normalized magnitude is m = floor(|sample| × scale / 2^SCALE_FRAC), clamped to 2^TH_W − 1. The most negative sample has magnitude 2^(IN_W−1).
- R4: For a width of N bits with L = 2^(N−1) magnitude levels, the boundaries are t_k = floor(2^TH_W × (3kL² + k³) / (4L³)) for k = 1 … L−1. This set is strictly increasing and non-uniform.
- R5: The low N−1 code bits equal the number of boundaries t_k with t_k ≤ m. A magnitude equal to a boundary therefore takes the higher interval, and any m at or above t_(L−1) gives L−1.
- R6: `out_valid` and its code appear exactly 3 + GRP_LOG clock edges (7 by default) after the edge that accepts `in_valid`, whatever the width. Back-to-back samples are accepted on every cycle.
- R7: Whenever `out_valid` is low, `out_code` is zero.
- R8: While reset is held, `out_valid` is low and `out_code` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | IN_W | Two's-complement I or Q sample |
| in_scale | input | SCALE_W | Unsigned gain, SCALE_FRAC fraction bits |
| in_wsel | input | 3 | Output width select (R1) |
| out_valid | output | 1 | Code present this cycle |
| out_code | output | 8 | Sign-magnitude code, right-aligned |

## Verification
Every result, valid flag and code alike, is due exactly seven rising edges after the edge that accepted its sample, independent of width. The bench drives a sample on each falling edge and pushes the value its model expects for that sample into a queue primed with seven idle entries. Just before driving the next sample, it pops the oldest entry and compares it with the outputs. Each output is thus checked at the exact cycle its result is due, and a result one cycle early or late shows up as a mismatch. The directed patterns place samples exactly on each boundary and one step below it. They also cover saturating gains and all three reserved selector values.

// File: rtl/lmq_pkg.sv
package lmq_pkg;
   localparam int NUM_WIDTHS = 5;
   localparam int CODE_W     = 8;
   localparam int LMAX_LOG   = CODE_W - 1;
   localparam int LMAX       = 1 << LMAX_LOG;
   localparam int WSEL_W     = 3;

   // selector index (already folded to 0..4) -> code width in bits
   function automatic int code_bits(input int widx);
      case (widx)
         0:       return 2;
         1:       return 3;
         2:       return 4;
         3:       return 6;
         default: return 8;
      endcase
   endfunction

   // cubic-spaced boundary k of an N-bit quantizer on a 2^th_w scale
   function automatic longint cubic_thr(input int th_w, input int nbits, input int k);
      longint l, kk, num;
      l   = longint'(1) << (nbits - 1);
      kk  = longint'(k);
      num = (longint'(1) << th_w) * (3 * kk * l * l + kk * kk * kk);
      return num / (4 * l * l * l);
   endfunction

   // boundary j of the shared 2^LMAX_LOG-level search space for width widx;
   // each real boundary is repeated over its stride, unused slots are out of range
   function automatic longint shared_thr(input int th_w, input int widx, input int j);
      int nb, lv, stride, k;
      nb     = code_bits(widx);
      lv     = 1 << (nb - 1);
      stride = LMAX / lv;
      k      = (j + stride - 1) / stride;
      if (k >= lv) return longint'(1) << th_w;
      return cubic_thr(th_w, nb, k);
   endfunction
endpackage

// File: rtl/lmq_normalize.sv
module lmq_normalize #(
   parameter int IN_W       = 12,
   parameter int SCALE_W    = 12,
   parameter int SCALE_FRAC = 8,
   parameter int TH_W       = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  v_i,
   input  logic [IN_W-1:0]       sample_i,
   input  logic [SCALE_W-1:0]    scale_i,
   input  logic [2:0]            wsel_i,
   output logic                  v_o,
   output logic                  neg_o,
   output logic [TH_W-1:0]       mag_o,
   output logic [2:0]            widx_o
);
   localparam int PROD_W  = IN_W + SCALE_W;
   localparam int MAG_MAX = (1 << TH_W) - 1;

   initial begin : param_checks
      assert (PROD_W - SCALE_FRAC >= TH_W)
         else $error("normalized product narrower than threshold word");
      assert (SCALE_FRAC < PROD_W) else $error("SCALE_FRAC too large");
   end

   logic [IN_W-1:0]   abs_c;
   logic [PROD_W-1:0] prod_c, shr_c;
   logic [TH_W-1:0]   mag_c;
   logic [2:0]        widx_c;

   always_comb begin
      abs_c  = sample_i[IN_W-1] ? (~sample_i + IN_W'(1)) : sample_i;
      prod_c = PROD_W'(abs_c) * PROD_W'(scale_i);
      shr_c  = prod_c >> SCALE_FRAC;
      if (shr_c > PROD_W'(MAG_MAX)) mag_c = '1;
      else                          mag_c = shr_c[TH_W-1:0];
      widx_c = (wsel_i > 3'd4) ? 3'd4 : wsel_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o    <= 1'b0;
         neg_o  <= 1'b0;
         mag_o  <= '0;
         widx_o <= '0;
      end else begin
         v_o    <= v_i;
         neg_o  <= sample_i[IN_W-1];
         mag_o  <= mag_c;
         widx_o <= widx_c;
      end
   end

   // a zero sample never produces a negative sign
   assert_zero_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (v_o && $past(v_i && sample_i == '0)) |-> !neg_o);
endmodule

// File: rtl/lmq_coarse.sv
module lmq_coarse #(
   parameter int TH_W    = 12,
   parameter int GRP_LOG = 4,
   parameter int TE_W    = TH_W + 1,
   parameter int TBL_W   = lmq_pkg::NUM_WIDTHS * lmq_pkg::LMAX * TE_W,
   parameter logic [TBL_W-1:0] TBL = '0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          v_i,
   input  logic                          neg_i,
   input  logic [TH_W-1:0]               mag_i,
   input  logic [2:0]                    widx_i,
   output logic                          v_o,
   output logic                          neg_o,
   output logic [TH_W-1:0]               mag_o,
   output logic [2:0]                    widx_o,
   output logic [lmq_pkg::LMAX_LOG-1:0]  cnt_o
);
   import lmq_pkg::*;
   localparam int G  = 1 << GRP_LOG;
   localparam int NG = LMAX >> GRP_LOG;

   logic [NG-2:0]       hit;
   logic [LMAX_LOG-1:0] cnt_c;

   // parallel rank: one comparator per group edge
   for (genvar g = 1; g < NG; g++) begin : g_edge
      assign hit[g-1] = {1'b0, mag_i} >= TBL[(int'(widx_i) * LMAX + g * G) * TE_W +: TE_W];
   end

   always_comb cnt_c = LMAX_LOG'($countones(hit)) << GRP_LOG;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o <= 1'b0; neg_o <= 1'b0; mag_o <= '0; widx_o <= '0; cnt_o <= '0;
      end else begin
         v_o <= v_i; neg_o <= neg_i; mag_o <= mag_i; widx_o <= widx_i; cnt_o <= cnt_c;
      end
   end

   // the chosen group brackets the magnitude
   assert_group_lower_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (v_o && cnt_o != '0) |->
         ({1'b0, mag_o} >= TBL[(int'(widx_o) * LMAX + int'(cnt_o)) * TE_W +: TE_W]));
   assert_group_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (v_o && int'(cnt_o) + G < LMAX) |->
         ({1'b0, mag_o} < TBL[(int'(widx_o) * LMAX + int'(cnt_o) + G) * TE_W +: TE_W]));
endmodule

// File: rtl/lmq_refine.sv
module lmq_refine #(
   parameter int TH_W  = 12,
   parameter int STEP  = 1,
   parameter int TE_W  = TH_W + 1,
   parameter int TBL_W = lmq_pkg::NUM_WIDTHS * lmq_pkg::LMAX * TE_W,
   parameter logic [TBL_W-1:0] TBL = '0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          v_i,
   input  logic                          neg_i,
   input  logic [TH_W-1:0]               mag_i,
   input  logic [2:0]                    widx_i,
   input  logic [lmq_pkg::LMAX_LOG-1:0]  cnt_i,
   output logic                          v_o,
   output logic                          neg_o,
   output logic [TH_W-1:0]               mag_o,
   output logic [2:0]                    widx_o,
   output logic [lmq_pkg::LMAX_LOG-1:0]  cnt_o
);
   import lmq_pkg::*;

   logic [LMAX_LOG-1:0] probe_c, cnt_c;
   logic [TE_W-1:0]     thr_c;

   // one comparator: try the midpoint of the remaining span
   always_comb begin
      probe_c = cnt_i + LMAX_LOG'(STEP);
      thr_c   = TBL[(int'(widx_i) * LMAX + int'(probe_c)) * TE_W +: TE_W];
      cnt_c   = ({1'b0, mag_i} >= thr_c) ? probe_c : cnt_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o <= 1'b0; neg_o <= 1'b0; mag_o <= '0; widx_o <= '0; cnt_o <= '0;
      end else begin
         v_o <= v_i; neg_o <= neg_i; mag_o <= mag_i; widx_o <= widx_i; cnt_o <= cnt_c;
      end
   end

   // each step only moves the index up, and by at most its own stride
   assert_step_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      v_o |-> (int'(cnt_o) >= int'($past(cnt_i)) &&
               int'(cnt_o) <= int'($past(cnt_i)) + STEP));
endmodule

// File: rtl/lm_quantizer.sv
module lm_quantizer #(
   parameter int IN_W       = 12,
   parameter int SCALE_W    = 12,
   parameter int SCALE_FRAC = 8,
   parameter int TH_W       = 12,
   parameter int GRP_LOG    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [IN_W-1:0]     in_sample,
   input  logic [SCALE_W-1:0]  in_scale,
   input  logic [2:0]          in_wsel,
   output logic                out_valid,
   output logic [7:0]          out_code
);
   import lmq_pkg::*;
   localparam int TE_W  = TH_W + 1;
   localparam int TBL_W = NUM_WIDTHS * LMAX * TE_W;
   localparam int LAT   = 3 + GRP_LOG;

   initial begin : param_checks
      assert (GRP_LOG >= 1 && GRP_LOG <= LMAX_LOG - 1) else $error("GRP_LOG out of range");
      assert (TH_W >= 8 && TH_W <= 24) else $error("TH_W out of range");
      assert (IN_W >= 2) else $error("IN_W too small");
      assert (LAT == GRP_LOG + 3) else $error("latency derivation");
   end

   function automatic logic [TBL_W-1:0] build_tbl();
      logic [TBL_W-1:0] t;
      t = '0;
      for (int w = 0; w < NUM_WIDTHS; w++)
         for (int j = 0; j < LMAX; j++)
            t[(w * LMAX + j) * TE_W +: TE_W] = TE_W'(shared_thr(TH_W, w, j));
      return t;
   endfunction

   localparam logic [TBL_W-1:0] TBL = build_tbl();

   // stage 0 is the coarse output, stage s+1 follows refine step s
   logic                v_s    [GRP_LOG+1];
   logic                neg_s  [GRP_LOG+1];
   logic [TH_W-1:0]     mag_s  [GRP_LOG+1];
   logic [2:0]          widx_s [GRP_LOG+1];
   logic [LMAX_LOG-1:0] cnt_s  [GRP_LOG+1];

   logic            n_v, n_neg;
   logic [TH_W-1:0] n_mag;
   logic [2:0]      n_widx;

   lmq_normalize #(
      .IN_W(IN_W), .SCALE_W(SCALE_W), .SCALE_FRAC(SCALE_FRAC), .TH_W(TH_W)
   ) u_norm (
      .clk(clk), .rst_n(rst_n),
      .v_i(in_valid), .sample_i(in_sample), .scale_i(in_scale), .wsel_i(in_wsel),
      .v_o(n_v), .neg_o(n_neg), .mag_o(n_mag), .widx_o(n_widx)
   );

   lmq_coarse #(
      .TH_W(TH_W), .GRP_LOG(GRP_LOG), .TE_W(TE_W), .TBL_W(TBL_W), .TBL(TBL)
   ) u_coarse (
      .clk(clk), .rst_n(rst_n),
      .v_i(n_v), .neg_i(n_neg), .mag_i(n_mag), .widx_i(n_widx),
      .v_o(v_s[0]), .neg_o(neg_s[0]), .mag_o(mag_s[0]), .widx_o(widx_s[0]),
      .cnt_o(cnt_s[0])
   );

   for (genvar s = 0; s < GRP_LOG; s++) begin : g_refine
      lmq_refine #(
         .TH_W(TH_W), .STEP(1 << (GRP_LOG - 1 - s)), .TE_W(TE_W), .TBL_W(TBL_W), .TBL(TBL)
      ) u_step (
         .clk(clk), .rst_n(rst_n),
         .v_i(v_s[s]), .neg_i(neg_s[s]), .mag_i(mag_s[s]), .widx_i(widx_s[s]),
         .cnt_i(cnt_s[s]),
         .v_o(v_s[s+1]), .neg_o(neg_s[s+1]), .mag_o(mag_s[s+1]), .widx_o(widx_s[s+1]),
         .cnt_o(cnt_s[s+1])
      );
   end

   // code assembly: sign on top, level index from the shared search space
   logic [7:0] code_c;
   always_comb begin
      int nb, idx;
      nb     = code_bits(int'(widx_s[GRP_LOG]));
      idx    = int'(cnt_s[GRP_LOG]) >> (LMAX_LOG - (nb - 1));
      code_c = 8'((int'(neg_s[GRP_LOG]) << (nb - 1)) | idx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_code  <= '0;
      end else begin
         out_valid <= v_s[GRP_LOG];
         out_code  <= v_s[GRP_LOG] ? code_c : 8'd0;
      end
   end

   assert_idle_code_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> out_code == 8'd0);
   assert_code_fits_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_code >> code_bits(int'($past(widx_s[GRP_LOG])))) == 8'd0);
endmodule

// File: tb/lm_quantizer_bench.sv
`timescale 1ns/1ps
module lm_quantizer_bench;
   localparam int LAT = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [11:0] in_sample = '0;
   logic [11:0] in_scale = '0;
   logic [2:0]  in_wsel = '0;
   logic        out_valid;
   logic [7:0]  out_code;

   int tests = 0;
   int fails = 0;
   int q_v[$];
   int q_code[$];
   int q_bits[$];

   always #4 clk = ~clk;

   lm_quantizer u_lm_quantizer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .in_scale(in_scale), .in_wsel(in_wsel), .out_valid(out_valid), .out_code(out_code)
   );

   function automatic int wbits(input int ws);
      case (ws)
         0: return 2; 1: return 3; 2: return 4; 3: return 6;
         default: return 8; // R1: 4..7 give 8 bits
      endcase
   endfunction

   // R4 boundary formula
   function automatic longint bound(input int nb, input int k);
      longint l = longint'(1) << (nb - 1);
      return (longint'(4096) * (3 * k * l * l + longint'(k) * k * k)) / (4 * l * l * l);
   endfunction

   // R3 normalization
   function automatic longint norm_mag(input int s, input int sc);
      longint a = (s < 0) ? -s : s;
      longint m = (a * sc) >> 8;
      return (m > 4095) ? 4095 : m;
   endfunction

   // R2 and R5 code
   function automatic int ref_code(input int s, input int sc, input int ws);
      int nb = wbits(ws);
      int idx = 0;
      longint m = norm_mag(s, sc);
      for (int k = 1; k < (1 << (nb - 1)); k++) if (bound(nb, k) <= m) idx++;
      return ((s < 0 ? 1 : 0) << (nb - 1)) | idx;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_out();
      int ev, ec, eb;
      ev = q_v.pop_front(); ec = q_code.pop_front(); eb = q_bits.pop_front();
      chk(int'(out_valid) == ev, "R6 valid timing", int'(out_valid), ev);
      if (ev == 1) begin
         chk((int'(out_code) >> eb) == 0, "R1 upper bits", int'(out_code), ec);
         chk(out_code[eb-1] == ec[eb-1], "R2 sign bit", int'(out_code[eb-1]), (ec >> (eb-1)) & 1);
         chk((int'(out_code) & ((1 << (eb-1)) - 1)) == (ec & ((1 << (eb-1)) - 1)),
             "R5 level index", int'(out_code), ec);
      end else begin
         chk(out_code == 8'd0, "R7 idle code", int'(out_code), 0);
      end
   endtask

   task automatic step(input bit v, input int s, input int sc, input int ws);
      @(negedge clk);
      if (q_v.size() == LAT) compare_out();
      in_valid  = v;
      in_sample = 12'(s);
      in_scale  = 12'(sc);
      in_wsel   = 3'(ws);
      q_v.push_back(v ? 1 : 0);
      q_code.push_back(v ? ref_code(s, sc, ws) : 0);
      q_bits.push_back(wbits(ws));
   endtask

   initial begin : watchdog
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R8: outputs held clear under reset
      chk(out_valid == 1'b0, "R8 reset valid", int'(out_valid), 0);
      chk(out_code == 8'd0, "R8 reset code", int'(out_code), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < LAT; i++) begin
         q_v.push_back(0); q_code.push_back(0); q_bits.push_back(2);
      end
      // R4/R5: every boundary, one below it, and its negative, each width
      for (int ws = 0; ws < 5; ws++) begin
         int nb = wbits(ws);
         for (int k = 1; k < (1 << (nb - 1)); k++) begin
            int t = int'(bound(nb, k));
            if (t < 2048) begin
               step(1, t, 256, ws);
               step(1, t - 1, 256, ws);
               step(1, -t, 256, ws);
            end else begin
               step(1, t >> 1, 512, ws);
               step(1, (t + 1) >> 1, 512, ws);
               step(1, -(t >> 1), 512, ws);
            end
         end
      end
      // R2: zero sample; R3: most negative sample and saturating gain
      for (int ws = 0; ws < 5; ws++) begin
         step(1, 0, 256, ws);
         step(1, -2048, 256, ws);
         step(1, 2047, 4095, ws);
         step(1, -2047, 4095, ws);
         step(1, 5, 0, ws);
      end
      // R1: reserved selector values behave as the widest setting
      for (int ws = 5; ws < 8; ws++) begin
         step(1, 1500, 300, ws);
         step(1, -900, 700, ws);
      end
      // R7: idle cycles with busy data lines; R6: isolated valids
      step(0, 1234, 999, 4);
      step(1, 77, 256, 2);
      step(0, -5, 3000, 1);
      step(0, 2047, 4095, 3);
      step(1, -300, 512, 0);
      // mixed traffic, widths changing every cycle
      for (int i = 0; i < 3000; i++) begin
         int s = int'($urandom_range(4095)) - 2048;
         step(($urandom_range(3) != 0), s, int'($urandom_range(1023)),
              int'($urandom_range(7)));
      end
      for (int i = 0; i < LAT + 1; i++) step(0, 0, 0, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule